// File: doc/BRIEF.md
# Gated Up/Down Pulse Counter Channel

This block is one channel of a 32-bit pulse counter. It samples an asynchronous pulse line with the system clock and counts each rising edge. The count goes up while the direction line is low and down while it is high. A gate line can halt counting, and a configuration bit decides whether the gate halts on a high level or on a low level. A controller can block counting altogether, or it can load a preset value into the counter. A configuration bit decides whether that load acts once on the rising edge of the request or on every cycle for as long as the request is held.

Two compare values can each be enabled on their own. When an up-count would make the count equal to an enabled compare value, the count becomes zero instead. These compare resets never happen while counting down.

The pulse, gate and direction lines each pass through a two-flop synchronizer and then a stability filter before the counter uses them. The live count and an up-counting flag are outputs, so that compare logic further downstream can use them. A second channel is a second instance of this block.

Top module: `pulse_counter_ch`

## Requirements
- R1: After reset the count is 0 and `counting_up` is 1.
- R2: While the direction line is low (up), each accepted rising edge of `pulse_in` adds 1 to the count.
- R3: While the direction line is high (down), each accepted rising edge subtracts 1 from the count, and `counting_up` reads 0.
- R4: The count wraps modulo 2^32 in both directions: 0xFFFFFFFF + 1 gives 0, and 0 - 1 gives 0xFFFFFFFF.
- R5: Counting is halted when the synchronized gate level equals `gate_halt_high`. With `gate_halt_high` = 1 a high gate halts the count; with 0 a low gate halts it.
- R6: While `inhibit` is 1, pulses do not change the count.
- R7: With `load_level_mode` = 0, a rising edge of `load_req` copies `preset` into the count once. Pulses that arrive while `load_req` stays high are then counted.
- R8: With `load_level_mode` = 1, the count equals `preset` in every cycle after a cycle in which `load_req` is 1, and pulses have no effect during that time. A load wins over a count event in the same cycle.
- R9: When an up-count would give a value equal to `cmp_a` while `cmp_a_en` = 1, or equal to `cmp_b` while `cmp_b_en` = 1, the count becomes 0 instead.
- R10: When a compare value's enable is 0, the count passes through that value without being cleared.
- R11: While counting down, reaching a compare value never clears the count.
- R12: A high pulse that lasts fewer than `FILT_LEN` clock cycles is not counted. A pulse that lasts 1 µs or longer is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse line to be counted |
| gate_in | input | 1 | Asynchronous gate line |
| dir_in | input | 1 | Asynchronous direction line: 0 = up, 1 = down |
| gate_halt_high | input | 1 | 1: a high gate halts counting; 0: a low gate halts counting |
| load_level_mode | input | 1 | 1: the load acts while `load_req` is held; 0: the load acts on the rising edge of `load_req` |
| load_req | input | 1 | Request to load the preset (synchronous) |
| inhibit | input | 1 | Blocks all counting |
| preset | input | 32 | Value copied in on a load |
| cmp_a | input | 32 | First auto-zero compare value |
| cmp_a_en | input | 1 | Enables the auto-zero on `cmp_a` |
| cmp_b | input | 32 | Second auto-zero compare value |
| cmp_b_en | input | 1 | Enables the auto-zero on `cmp_b` |
| count | output | 32 | Live count |
| counting_up | output | 1 | 1 while the filtered direction selects up-counting |

## Verification
The assertions check on every cycle that a level-mode load and an edge-mode load put `preset` into the count on the next cycle. They also check that `inhibit` freezes the count unless a load is requested. Outside a load, the count may only hold, step by one, or go to zero, and it never jumps to zero while counting down except from 1.

The bench scenarios cover what needs a particular pulse history:
- gate polarity in both settings;
- wraparound at both ends of the range;
- compare clears with the enables on and off, and through the second compare value;
- a second compare clear in one run, and counting down through a compare value;
- rejection of a glitch that is shorter than the filter window.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned DEF_CNT_W    = 32;
  localparam int unsigned DEF_SYNC_LEN = 2;
  localparam int unsigned DEF_FILT_LEN = 4;

  // Asynchronous lines grouped so that one synchronizer and one filter serve all three
  typedef struct packed {
    logic pulse;
    logic gate;
    logic dir;
  } pc_lines_t;

  localparam int unsigned LINES_W = $bits(pc_lines_t);
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pc_filt.sv
module pc_filt #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < int'(WIDTH); g++) begin : g_bit
      logic [DEPTH-1:0] hist_q, hist_d;
      logic             out_q, out_d;

      always_comb begin
        hist_d = {hist_q[DEPTH-2:0], d[g]};
        out_d  = out_q;
        if (&hist_q)       out_d = 1'b1;
        else if (~|hist_q) out_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
          out_q  <= 1'b0;
        end else begin
          hist_q <= hist_d;
          out_q  <= out_d;
        end
      end

      assign q[g] = out_q;
    end
  endgenerate
endmodule

// File: rtl/pc_core.sv
module pc_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_f,
  input  logic             gate_f,
  input  logic             dir_f,
  input  logic             gate_halt_high,
  input  logic             load_level_mode,
  input  logic             load_req,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic             cmp_a_en,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             cmp_b_en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             pulse_prev_q, load_prev_q;
  logic             pulse_rise, load_fire, run_en, cmp_hit;
  logic [CNT_W-1:0] inc_val, dec_val;

  always_comb begin
    pulse_rise = pulse_f & ~pulse_prev_q;
    load_fire  = load_level_mode ? load_req : (load_req & ~load_prev_q);
    run_en     = ~inhibit & (gate_f != gate_halt_high);
    inc_val    = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    dec_val    = count_q - {{(CNT_W-1){1'b0}}, 1'b1};
    cmp_hit    = (cmp_a_en && inc_val == cmp_a) || (cmp_b_en && inc_val == cmp_b);
    count_d    = count_q;
    if (load_fire) begin
      count_d = preset;
    end else if (pulse_rise && run_en) begin
      if (dir_f) count_d = dec_val;
      else       count_d = cmp_hit ? '0 : inc_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q      <= '0;
      pulse_prev_q <= 1'b0;
      load_prev_q  <= 1'b0;
    end else begin
      count_q      <= count_d;
      pulse_prev_q <= pulse_f;
      load_prev_q  <= load_req;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/pulse_counter_ch.sv
module pulse_counter_ch
  import pc_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN,
  parameter int unsigned FILT_LEN = DEF_FILT_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             gate_in,
  input  logic             dir_in,
  input  logic             gate_halt_high,
  input  logic             load_level_mode,
  input  logic             load_req,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic             cmp_a_en,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             cmp_b_en,
  output logic [CNT_W-1:0] count,
  output logic             counting_up
);
  pc_lines_t raw_l, sync_l, filt_l;

  assign raw_l = '{pulse: pulse_in, gate: gate_in, dir: dir_in};

  pc_sync #(.WIDTH(LINES_W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_l), .q(sync_l)
  );

  pc_filt #(.WIDTH(LINES_W), .DEPTH(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .d(sync_l), .q(filt_l)
  );

  pc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .pulse_f(filt_l.pulse), .gate_f(filt_l.gate), .dir_f(filt_l.dir),
    .gate_halt_high(gate_halt_high), .load_level_mode(load_level_mode),
    .load_req(load_req), .inhibit(inhibit), .preset(preset),
    .cmp_a(cmp_a), .cmp_a_en(cmp_a_en), .cmp_b(cmp_b), .cmp_b_en(cmp_b_en),
    .count(count)
  );

  assign counting_up = ~filt_l.dir;
endmodule

// File: rtl/pc_chk.sv
module pc_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_level_mode,
  input logic             load_req,
  input logic             inhibit,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] count,
  input logic             counting_up
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R8
  level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_level_mode && load_req) |=> count == $past(preset));

  // R7
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_level_mode && $rose(load_req)) |=> count == $past(preset));

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !load_req) |=> count == $past(count));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> (count == $past(count) || count == $past(count) + ONE ||
                   count == $past(count) - ONE || count == '0));

  // R11
  no_down_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_req && !counting_up && count != ONE && count != '0) |=> count != '0);
endmodule

bind pulse_counter_ch pc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_level_mode(load_level_mode),
  .load_req(load_req), .inhibit(inhibit), .preset(preset),
  .count(count), .counting_up(counting_up)
);

// File: tb/tb_pulse_counter_ch.sv
module tb_pulse_counter_ch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pulse_in, gate_in, dir_in, gate_halt_high, load_level_mode;
  logic        load_req, inhibit, cmp_a_en, cmp_b_en, counting_up;
  logic [31:0] preset, cmp_a, cmp_b, count;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pulse_counter_ch dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_in(gate_in), .dir_in(dir_in),
    .gate_halt_high(gate_halt_high), .load_level_mode(load_level_mode),
    .load_req(load_req), .inhibit(inhibit), .preset(preset),
    .cmp_a(cmp_a), .cmp_a_en(cmp_a_en), .cmp_b(cmp_b), .cmp_b_en(cmp_b_en),
    .count(count), .counting_up(counting_up)
  );

  // row: preset[75:44] dir[43] gate[42] halt_high[41] inhibit[40] pulses[39:32] expected[31:0]
  localparam logic [75:0] VEC [8] = '{
    {32'd100,        1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 32'd105},        // R2
    {32'd100,        1'b1, 1'b0, 1'b1, 1'b0, 8'd5, 32'd95},         // R3
    {32'hFFFF_FFFE,  1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 32'd1},          // R4
    {32'd1,          1'b1, 1'b0, 1'b1, 1'b0, 8'd3, 32'hFFFF_FFFE},  // R4
    {32'd50,         1'b0, 1'b1, 1'b1, 1'b0, 8'd4, 32'd50},         // R5
    {32'd50,         1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 32'd50},         // R5
    {32'd50,         1'b0, 1'b1, 1'b0, 1'b0, 8'd3, 32'd53},         // R5
    {32'd50,         1'b0, 1'b0, 1'b1, 1'b1, 8'd4, 32'd50}          // R6
  };
  localparam string VEC_REQ [8] = '{"R2", "R3", "R4", "R4", "R5", "R5", "R5", "R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pulses(input int n, input int width);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1; wait_cyc(width);
      pulse_in = 1'b0; wait_cyc(12);
    end
  endtask

  task automatic edge_load(input logic [31:0] v);
    preset = v; load_level_mode = 1'b0;
    load_req = 1'b1; wait_cyc(1);
    load_req = 1'b0; wait_cyc(2);
  endtask

  initial begin
    wait_cyc(100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pulse_in = 0; gate_in = 0; dir_in = 0; gate_halt_high = 1;
    load_level_mode = 0; load_req = 0; inhibit = 0; preset = '0;
    cmp_a = '0; cmp_b = '0; cmp_a_en = 0; cmp_b_en = 0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 count", count, 32'd0);
    chk("R1 up flag", {31'd0, counting_up}, 32'd1);

    for (int r = 0; r < 8; r++) begin
      dir_in = VEC[r][43]; gate_in = VEC[r][42];
      gate_halt_high = VEC[r][41]; inhibit = VEC[r][40];
      wait_cyc(15);
      edge_load(VEC[r][75:44]);
      send_pulses(int'(VEC[r][39:32]), 10);
      chk(VEC_REQ[r], count, VEC[r][31:0]);
    end
    inhibit = 0; gate_in = 0; gate_halt_high = 1;

    dir_in = 1; wait_cyc(15);
    chk("R3 up flag", {31'd0, counting_up}, 32'd0);
    dir_in = 0; wait_cyc(15);

    // R4 wrap at the all-ones end
    edge_load(32'hFFFF_FFFF); send_pulses(1, 10);
    chk("R4 up wrap", count, 32'd0);
    dir_in = 1; wait_cyc(15); send_pulses(1, 10);
    chk("R4 down wrap", count, 32'hFFFF_FFFF);
    dir_in = 0; wait_cyc(15);

    // R7 edge load held high: counting resumes
    preset = 32'd200; load_req = 1; wait_cyc(3);
    chk("R7 loaded", count, 32'd200);
    send_pulses(3, 10);
    chk("R7 counts while held", count, 32'd203);
    load_req = 0; wait_cyc(2);

    // R8 level load holds the preset
    load_level_mode = 1; preset = 32'd300; load_req = 1; wait_cyc(2);
    chk("R8 level load", count, 32'd300);
    send_pulses(3, 10);
    chk("R8 pulses ignored", count, 32'd300);
    load_req = 0; load_level_mode = 0; wait_cyc(2);

    // R9 compare clear on A then normal counting
    cmp_a = 32'd10; cmp_a_en = 1;
    edge_load(32'd7); send_pulses(3, 10);
    chk("R9 cmp_a clear", count, 32'd0);
    send_pulses(2, 10);
    chk("R9 after clear", count, 32'd2);
    cmp_b = 32'd20; cmp_b_en = 1;
    edge_load(32'd18); send_pulses(2, 10);
    chk("R9 cmp_b clear", count, 32'd0);
    cmp_b_en = 0;

    // R10 disabled compare
    cmp_a_en = 0;
    edge_load(32'd7); send_pulses(3, 10);
    chk("R10 no clear", count, 32'd10);

    // R11 counting down through an enabled compare value
    cmp_a_en = 1; dir_in = 1; wait_cyc(15);
    edge_load(32'd13); send_pulses(3, 10);
    chk("R11 down at cmp", count, 32'd10);
    send_pulses(1, 10);
    chk("R11 down past cmp", count, 32'd9);
    cmp_a_en = 0; dir_in = 0; wait_cyc(15);

    // R12 glitch rejection and minimum-width acceptance (1 us = 125 cycles)
    edge_load(32'd40);
    send_pulses(1, 2);
    chk("R12 glitch rejected", count, 32'd40);
    send_pulses(1, 125);
    chk("R12 1us pulse counted", count, 32'd41);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule